// File: doc/BRIEF.md
# Thermal Alarm Window Comparator

This block watches a stream of signed temperature samples and compares each one with three programmable limits: an upper window edge, a lower window edge and a critical ceiling. It keeps one status flag for each limit. Each flag uses a selectable hysteresis band, so that a reading that hovers near a limit does not make the flag toggle.

From the flags it drives an event indication in one of three modes. In comparator mode the event simply follows the flags. In interrupt mode the event latches on a fresh trip and software clears it. In critical-only mode only the critical flag can raise the event. The event is presented both as a raw status bit and as a pin level, after a polarity choice and an output enable have been applied. A shutdown input freezes monitoring.

Temperatures use 1/16 °C per LSB. The limits share that scale but carry 0.25 °C resolution. The block sits between a temperature converter that delivers samples with a valid strobe and a configuration register bank that supplies the limits and the mode bits.

Top module: `thermal_window_cmp`

## Requirements
- R1: The above flag sets on a valid sample strictly greater than the upper limit. It clears on a valid sample strictly less than the upper limit minus the hysteresis. Otherwise it keeps its value.
- R2: The below flag sets on a valid sample strictly less than the lower limit minus the hysteresis. It clears on a valid sample strictly greater than the lower limit. Otherwise it keeps its value.
- R3: The critical flag sets on a valid sample strictly greater than the critical limit. It clears on a valid sample strictly less than the critical limit minus the hysteresis. Otherwise it keeps its value.
- R4: All values are 13-bit two's complement at 1/16 °C per LSB, and all comparisons are signed. Bits 1:0 of every limit input are ignored and treated as zero. The hysteresis code maps 0 to 0, 1 to 24 (1.5 °C), 2 to 48 (3 °C) and 3 to 96 (6 °C) LSBs.
- R5: Flags change only at a clock edge where the sample-valid strobe is high. The new value is visible after that edge.
- R6: While shutdown is high, samples are ignored and all three flags hold their values.
- R7: In comparator mode (event mode 0, critical-only 0), the event status equals the OR of the three flags.
- R8: In interrupt mode (event mode 1, critical-only 0), a latch sets when any flag goes from 0 to 1 on an update. A one on the clear input resets the latch, and a trip in the same cycle wins over the clear. A condition that is still present after a clear does not set the latch again.
- R9: In interrupt mode, the event status is also high whenever the critical flag is set, and the clear input has no effect on it.
- R10: With critical-only set (in either event mode), the event status equals the critical flag, and the clear input has no effect.
- R11: When the output enable is high, the event pin equals the status if polarity is 1, and the inverted status if polarity is 0. When the output enable is low, the pin sits at the inactive level, which is the inverse of the polarity bit.
- R12: After reset, all flags, the interrupt latch and the event status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_in | input | 13 | Signed temperature sample, 1/16 °C per LSB |
| temp_vld | input | 1 | Sample valid strobe |
| lim_hi | input | 13 | Upper window limit (bits 1:0 ignored) |
| lim_lo | input | 13 | Lower window limit (bits 1:0 ignored) |
| lim_crit | input | 13 | Critical limit (bits 1:0 ignored) |
| hyst_sel | input | 2 | Hysteresis code |
| evt_mode | input | 1 | 0 comparator, 1 interrupt |
| crit_only | input | 1 | Event raised only by the critical flag |
| evt_pol | input | 1 | 1 active-high pin, 0 active-low pin |
| evt_oe | input | 1 | Event pin output enable |
| evt_clr | input | 1 | Clears the interrupt latch |
| shutdown | input | 1 | Freezes monitoring |
| flag_above | output | 1 | Above-window flag |
| flag_below | output | 1 | Below-window flag |
| flag_crit | output | 1 | Critical flag |
| evt_status | output | 1 | Event being asserted |
| evt_pin | output | 1 | Event pin level |

## Verification
The assertions check on every cycle that the flags hold when no update is allowed and that each flag sets after a sample beyond its limit. They also check that the critical flag forces the status in every mode, that critical-only mode tracks that flag, and that a disabled pin rests at its inactive level. Hysteresis clearing, the interrupt latch's one-shot behaviour after a clear, and limit masking only show up over sequences of samples. The bench's ramp sweeps cover these across every hysteresis code and event mode, checked against an arithmetic model.

// File: rtl/thermal_window_cmp.sv
module thermal_window_cmp #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_in,
  input  logic          temp_vld,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic [TW-1:0] lim_crit,
  input  logic [1:0]    hyst_sel,
  input  logic          evt_mode,
  input  logic          crit_only,
  input  logic          evt_pol,
  input  logic          evt_oe,
  input  logic          evt_clr,
  input  logic          shutdown,
  output logic          flag_above,
  output logic          flag_below,
  output logic          flag_crit,
  output logic          evt_status,
  output logic          evt_pin
);
  localparam int EW = TW + 1;

  logic signed [EW-1:0] t, th, tl, tc, hy;
  logic upd, nx_above, nx_below, nx_crit, trip, latch;

  assign t  = {temp_in[TW-1], temp_in};
  assign th = {lim_hi[TW-1], lim_hi[TW-1:2], 2'b00};
  assign tl = {lim_lo[TW-1], lim_lo[TW-1:2], 2'b00};
  assign tc = {lim_crit[TW-1], lim_crit[TW-1:2], 2'b00};

  always_comb begin
    case (hyst_sel)
      2'd1:    hy = EW'(24);
      2'd2:    hy = EW'(48);
      2'd3:    hy = EW'(96);
      default: hy = '0;
    endcase
  end

  assign upd      = temp_vld & ~shutdown;
  assign nx_above = (t > th) ? 1'b1 : (t < th - hy) ? 1'b0 : flag_above;
  assign nx_below = (t < tl - hy) ? 1'b1 : (t > tl) ? 1'b0 : flag_below;
  assign nx_crit  = (t > tc) ? 1'b1 : (t < tc - hy) ? 1'b0 : flag_crit;
  assign trip     = upd & ((nx_above & ~flag_above) | (nx_below & ~flag_below) |
                           (nx_crit & ~flag_crit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_above <= 1'b0;
      flag_below <= 1'b0;
      flag_crit  <= 1'b0;
      latch      <= 1'b0;
    end else begin
      if (upd) begin
        flag_above <= nx_above;
        flag_below <= nx_below;
        flag_crit  <= nx_crit;
      end
      latch <= evt_mode & ((latch & ~evt_clr) | trip);
    end
  end

  assign evt_status = crit_only ? flag_crit :
                      evt_mode  ? (latch | flag_crit) :
                                  (flag_above | flag_below | flag_crit);
  assign evt_pin    = evt_oe ? (evt_status ^ ~evt_pol) : ~evt_pol;
endmodule

module thermal_window_cmp_chk #(
  parameter int TW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] temp_in,
  input logic          temp_vld,
  input logic [TW-1:0] lim_hi,
  input logic [TW-1:0] lim_lo,
  input logic [TW-1:0] lim_crit,
  input logic [1:0]    hyst_sel,
  input logic          crit_only,
  input logic          evt_pol,
  input logic          evt_oe,
  input logic          shutdown,
  input logic          flag_above,
  input logic          flag_below,
  input logic          flag_crit,
  input logic          evt_status,
  input logic          evt_pin
);
  int tv, hv, lv, cv, hh;
  always_comb begin
    tv = int'($signed(temp_in));
    hv = int'($signed(lim_hi));   hv = hv - (hv & 3);
    lv = int'($signed(lim_lo));   lv = lv - (lv & 3);
    cv = int'($signed(lim_crit)); cv = cv - (cv & 3);
    hh = (hyst_sel == 2'd0) ? 0 : (24 << (hyst_sel - 2'd1));
  end

  AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(temp_vld && !shutdown) |=> $stable({flag_above, flag_below, flag_crit})); // R5
  AST_HOLD_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> $stable({flag_above, flag_below, flag_crit})); // R6
  AST_ABOVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_vld && !shutdown && tv > hv) |=> flag_above); // R1
  AST_BELOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_vld && !shutdown && tv < lv - hh) |=> flag_below); // R2
  AST_CRIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_vld && !shutdown && tv > cv) |=> flag_crit); // R3
  AST_CRIT_FORCES_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_crit |-> evt_status); // R9
  AST_CRIT_ONLY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    crit_only |-> (evt_status == flag_crit)); // R10
  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_oe |-> (evt_pin != evt_pol)); // R11
endmodule

bind thermal_window_cmp thermal_window_cmp_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .temp_vld(temp_vld),
  .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit), .hyst_sel(hyst_sel),
  .crit_only(crit_only), .evt_pol(evt_pol), .evt_oe(evt_oe), .shutdown(shutdown),
  .flag_above(flag_above), .flag_below(flag_below), .flag_crit(flag_crit),
  .evt_status(evt_status), .evt_pin(evt_pin)
);

// File: tb/tb_thermal_window_cmp.sv
module tb_thermal_window_cmp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] temp_in = '0, lim_hi = '0, lim_lo = '0, lim_crit = '0;
  logic temp_vld = 1'b0, evt_mode = 1'b0, crit_only = 1'b0;
  logic evt_pol = 1'b0, evt_oe = 1'b1, evt_clr = 1'b0, shutdown = 1'b0;
  logic [1:0] hyst_sel = '0;
  logic flag_above, flag_below, flag_crit, evt_status, evt_pin;

  int total = 0, bad = 0;
  bit m_ab, m_be, m_cr, m_lat;
  int c_hi, c_lo, c_cr, c_hy;

  always #10 clk = ~clk;

  thermal_window_cmp dut (
    .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .temp_vld(temp_vld),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit), .hyst_sel(hyst_sel),
    .evt_mode(evt_mode), .crit_only(crit_only), .evt_pol(evt_pol), .evt_oe(evt_oe),
    .evt_clr(evt_clr), .shutdown(shutdown), .flag_above(flag_above),
    .flag_below(flag_below), .flag_crit(flag_crit), .evt_status(evt_status),
    .evt_pin(evt_pin)
  );

  function automatic int msk(int v);
    return v - (v & 3);
  endfunction

  task automatic check(string req);
    bit st, pn;
    st = crit_only ? m_cr : evt_mode ? (m_lat | m_cr) : (m_ab | m_be | m_cr);
    pn = evt_oe ? (evt_pol ? st : !st) : !evt_pol;
    total++;
    if ({flag_above, flag_below, flag_crit, evt_status, evt_pin} !== {m_ab, m_be, m_cr, st, pn}) begin
      bad++;
      $display("FAIL %s t=%0d act=%b exp=%b", req, $signed(temp_in),
               {flag_above, flag_below, flag_crit, evt_status, evt_pin},
               {m_ab, m_be, m_cr, st, pn});
    end
  endtask

  // drives at a negedge, model follows the edge, checks at the next negedge
  task automatic step(int tv, bit vld, bit clr, bit sd, string req);
    bit na, nb, nc, tr;
    temp_in = 13'(tv); temp_vld = vld; evt_clr = clr; shutdown = sd;
    na = m_ab; nb = m_be; nc = m_cr;
    if (vld && !sd) begin
      if (tv > c_hi) na = 1; else if (tv < c_hi - c_hy) na = 0;
      if (tv < c_lo - c_hy) nb = 1; else if (tv > c_lo) nb = 0;
      if (tv > c_cr) nc = 1; else if (tv < c_cr - c_hy) nc = 0;
    end
    tr = (na & !m_ab) | (nb & !m_be) | (nc & !m_cr);
    m_lat = evt_mode & ((m_lat & !clr) | tr);
    m_ab = na; m_be = nb; m_cr = nc;
    @(negedge clk);
    check(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; temp_vld = 0; evt_clr = 0; shutdown = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_ab = 0; m_be = 0; m_cr = 0; m_lat = 0;
  endtask

  initial begin
    #3000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    c_lo = 160; c_cr = 1280; c_hy = 0;
    lim_lo = 13'(c_lo); lim_crit = 13'(c_cr);
    lim_hi = 13'(640); c_hi = 640;
    do_reset();
    check("R12 reset state");
    for (int hc = 0; hc < 4; hc++) begin
      for (int md = 0; md < 3; md++) begin
        int idx = 0;
        hyst_sel = 2'(hc);
        c_hy = (hc == 0) ? 0 : (24 << (hc - 1));
        lim_hi = 13'(640 + ((hc == 2) ? 3 : 0));   // R4 low bits ignored
        lim_crit = 13'(1280 + ((hc == 3) ? 2 : 0));
        c_hi = msk(640); c_cr = msk(1280);
        evt_mode = (md == 1); crit_only = (md == 2);
        evt_pol = 1'b0; evt_oe = 1'b1;
        do_reset();
        check("R12 reset per config");
        for (int dir = 0; dir < 2; dir++) begin
          for (int k = 0; k <= 500; k++) begin
            int tv = (dir == 0) ? (-480 + 4 * k) : (1520 - 4 * k);
            idx++;
            evt_pol = idx[6];
            evt_oe = (idx % 13) != 0;
            if (idx % 11 == 0)
              step((tv > 500) ? -4000 : 4000, 1'b0, 1'b0, 1'b0, "R5 no strobe");
            else
              step(tv, 1'b1, (idx % 29) == 0, 1'b0,
                   (md == 0) ? "R1 R2 R3 R7 R11" : (md == 1) ? "R8 R9 R11" : "R10 R11");
          end
        end
        step(4095, 1'b1, 1'b0, 1'b1, "R6 shutdown hot");
        step(-4096, 1'b1, 1'b1, 1'b1, "R6 shutdown cold");
        step(1400, 1'b1, 1'b0, 1'b1, "R6 shutdown mid");
        step(1400, 1'b1, 1'b0, 1'b0, "R3 R4 after shutdown");
        step(1400, 1'b0, 1'b1, 1'b0, "R9 R10 clear with crit");
        step(-300, 1'b1, 1'b0, 1'b0, "R2 R4 negative");
        step(-300, 1'b0, 1'b1, 1'b0, "R8 clear");
        step(-300, 1'b1, 1'b0, 1'b0, "R8 no retrigger");
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule